// File: doc/BRIEF.md
# Stack Selector Push/Pop Unit

This block works out everything a stack access of a 16-bit segment selector needs: the moved stack pointer, the offset of the access in the stack segment, the byte lanes touched, the data to write and whether the access faults. A request carries the current stack pointer, the operand size (2 or 4 bytes), the stack segment size (16 or 32 bits), the segment limit, the selector and a mode bit. The mode bit picks one of two behaviours. In the narrow mode only two bytes are ever touched. In the wide mode the access is as wide as the operand.

A pop can also carry a stack-pointer-based store destination (pop-to-memory). The block then forms that destination from the popped stack pointer plus an offset (scaled index plus displacement). In a 16-bit stack segment the pointer can wrap past 64 KiB. The two modes treat that wrap differently.

The control is a two-state machine. `ST_IDLE` holds `req_ready` high; the transition *accept* (`req_valid` while idle) registers the result and moves to `ST_RESP`. `ST_RESP` drives `rsp_valid` for one cycle, and the transition *retire* returns unconditionally to `ST_IDLE`.

Top module: `ssel_unit`

## Requirements
- R1: A push lowers the stack pointer by the operand size (2 when `req_opsz32`=0, 4 when 1) and accesses the lowered pointer; a pop accesses the current pointer.
- R2: In narrow mode (`req_mode_wide`=0), a push that does not fault writes only lanes 0 and 1 (`rsp_be`=4'b0011, bit k enables the byte at offset+k), with the selector in `rsp_wdata[15:0]`, for either operand size.
- R3: In wide mode a 32-bit push enables all four lanes (`rsp_be`=4'b1111) and `rsp_wdata[31:16]` is zero; a 16-bit push enables 4'b0011.
- R4: In narrow mode a pop reads two bytes (`rsp_be`=4'b0011, `rsp_rd32`=0) yet raises the pointer by the full operand size.
- R5: In wide mode a pop reads the operand size (`rsp_rd32`=1 and `rsp_be`=4'b1111 for 32-bit) and raises the pointer by the operand size.
- R6: An access faults when its last byte offset (offset+3 in wide mode with a 32-bit operand, otherwise offset+1) exceeds `req_limit`; the same 32-bit access in narrow mode faults only when offset+1 exceeds the limit.
- R7: On any fault, `rsp_fault`=1, `rsp_new_sp` equals the request pointer, and `rsp_we`, `rsp_dst_we` and `rsp_be` are all zero.
- R8: With a 16-bit stack segment (`req_ss32`=0) only the low 16 bits of the pointer move, modulo 64 KiB; the upper 16 bits pass through and the access offset is the zero-extended low half.
- R9: With a 32-bit stack segment the pointer arithmetic uses all 32 bits with no 64 KiB wrap.
- R10: For a pop-to-memory in narrow mode, `rsp_dst_addr` is the popped offset (0 after a wrap) plus `req_dst_off`, and `rsp_dst_we`=1.
- R11: For a pop-to-memory that wraps a 16-bit segment in wide mode, the result faults when `req_limit` ≤ 0xFFFF; otherwise `rsp_dst_addr` = 0x10000 + `req_dst_off`.
- R12: `req_ready` is high only in `ST_IDLE`; `rsp_valid` rises in the cycle after an accepted request and stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_pop_to_mem | input | 1 | Pop stores to a pointer-based destination |
| req_opsz32 | input | 1 | Operand size 4 bytes (else 2) |
| req_ss32 | input | 1 | 32-bit stack segment (else 16-bit) |
| req_mode_wide | input | 1 | 1 = wide mode, 0 = narrow mode |
| req_sp | input | 32 | Current stack pointer |
| req_limit | input | 32 | Stack segment limit (expand-up) |
| req_sel | input | 16 | Selector to push |
| req_dst_off | input | 32 | Scaled index plus displacement of the destination |
| rsp_valid | output | 1 | Result valid |
| rsp_addr | output | 32 | Stack access offset |
| rsp_be | output | 4 | Byte lane enables |
| rsp_we | output | 1 | Stack write strobe |
| rsp_wdata | output | 32 | Write data |
| rsp_rd32 | output | 1 | Pop reads 4 bytes |
| rsp_new_sp | output | 32 | Updated stack pointer |
| rsp_fault | output | 1 | Limit or wrap fault |
| rsp_dst_addr | output | 32 | Pop-to-memory destination offset |
| rsp_dst_we | output | 1 | Destination write strobe |

## Verification
Pushes and pops run in both modes with both operand sizes, so lane enables, upper write data and the step size show whether mode and operand size are decoded separately. Limits are placed so the third byte of a 32-bit access crosses them; the result must differ between the modes and catch an off-by-one in the limit compare. Pointers at 0xFFFC and 0xFFFE are popped in 16- and 32-bit segments, and a push from low half 0 is issued, to tell the 64 KiB wrap from full-width arithmetic. A wrapping pop-to-memory is repeated in narrow mode and in wide mode with a limit on each side of 0xFFFF, which separates all three destination outcomes.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ssel_state_e;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  be;
        logic        we;
        logic [31:0] wdata;
        logic        rd32;
        logic [31:0] new_sp;
        logic        fault;
        logic [31:0] dst_addr;
        logic        dst_we;
    } ssel_rsp_t;
endpackage

// File: rtl/ssel_addr.sv
module ssel_addr #(
    parameter int SP_W   = 32,
    parameter int WRAP_W = 16
) (
    input  logic [SP_W-1:0]   sp,
    input  logic              pop,
    input  logic              opsz32,
    input  logic              ss32,
    output logic [SP_W-1:0]   next_sp,
    output logic [SP_W-1:0]   acc_off,
    output logic [SP_W-1:0]   popped_off,
    output logic [SP_W-1:0]   popped_raw,
    output logic              pop_wrap
);
    localparam int HI_W = SP_W - WRAP_W;

    logic [SP_W-1:0]   step;
    logic [SP_W-1:0]   full_sum;
    logic [WRAP_W:0]   low_sum;
    logic [SP_W-1:0]   low_ext;
    logic [SP_W-1:0]   cur_off;

    always_comb begin
        step     = opsz32 ? SP_W'(4) : SP_W'(2);
        full_sum = pop ? (sp + step) : (sp - step);
        low_sum  = pop ? ({1'b0, sp[WRAP_W-1:0]} + step[WRAP_W:0])
                       : ({1'b0, sp[WRAP_W-1:0]} - step[WRAP_W:0]);
        low_ext  = {{HI_W{1'b0}}, low_sum[WRAP_W-1:0]};
        cur_off  = ss32 ? sp : {{HI_W{1'b0}}, sp[WRAP_W-1:0]};

        next_sp    = ss32 ? full_sum : {sp[SP_W-1:WRAP_W], low_sum[WRAP_W-1:0]};
        popped_off = ss32 ? full_sum : low_ext;
        acc_off    = pop ? cur_off : popped_off;
        popped_raw = {{(HI_W-1){1'b0}}, low_sum};
        pop_wrap   = pop && !ss32 && low_sum[WRAP_W];
    end
endmodule

// File: rtl/ssel_check.sv
module ssel_check #(
    parameter int SP_W = 32,
    parameter int BE_W = 4
) (
    input  logic [SP_W-1:0] acc_off,
    input  logic            wide,
    input  logic [SP_W-1:0] limit,
    output logic            lim_fault,
    output logic [BE_W-1:0] lanes
);
    logic [SP_W:0] last_byte;

    always_comb begin
        last_byte = {1'b0, acc_off} + (wide ? (SP_W+1)'(BE_W-1) : (SP_W+1)'(1));
        lim_fault = last_byte > {1'b0, limit};
        lanes     = wide ? {BE_W{1'b1}} : BE_W'(2'b11);
    end
endmodule

// File: rtl/ssel_unit.sv
module ssel_unit
    import ssel_pkg::*;
#(
    parameter int SP_W   = 32,
    parameter int SEL_W  = 16,
    parameter int WRAP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_pop,
    input  logic              req_pop_to_mem,
    input  logic              req_opsz32,
    input  logic              req_ss32,
    input  logic              req_mode_wide,
    input  logic [SP_W-1:0]   req_sp,
    input  logic [SP_W-1:0]   req_limit,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [SP_W-1:0]   req_dst_off,
    output logic              rsp_valid,
    output logic [SP_W-1:0]   rsp_addr,
    output logic [3:0]        rsp_be,
    output logic              rsp_we,
    output logic [SP_W-1:0]   rsp_wdata,
    output logic              rsp_rd32,
    output logic [SP_W-1:0]   rsp_new_sp,
    output logic              rsp_fault,
    output logic [SP_W-1:0]   rsp_dst_addr,
    output logic              rsp_dst_we
);
    localparam logic [SP_W-1:0] SEG64K_MAX = SP_W'((1 << WRAP_W) - 1);

    ssel_state_e state_q, state_d;
    logic        accept;

    logic [SP_W-1:0] next_sp, acc_off, popped_off, popped_raw;
    logic            pop_wrap, wide, lim_fault, dst_fault, any_fault;
    logic [3:0]      lanes;
    logic [SP_W-1:0] dst_base;

    assign wide   = req_mode_wide && req_opsz32;
    assign accept = req_valid && (state_q == ST_IDLE);

    ssel_addr #(.SP_W(SP_W), .WRAP_W(WRAP_W)) u_addr (
        .sp(req_sp), .pop(req_pop), .opsz32(req_opsz32), .ss32(req_ss32),
        .next_sp(next_sp), .acc_off(acc_off), .popped_off(popped_off),
        .popped_raw(popped_raw), .pop_wrap(pop_wrap)
    );

    ssel_check #(.SP_W(SP_W), .BE_W(4)) u_check (
        .acc_off(acc_off), .wide(wide), .limit(req_limit),
        .lim_fault(lim_fault), .lanes(lanes)
    );

    always_comb begin
        dst_base  = (pop_wrap && req_mode_wide) ? popped_raw : popped_off;
        dst_fault = req_pop && req_pop_to_mem && pop_wrap && req_mode_wide
                    && (req_limit <= SEG64K_MAX);
        any_fault = lim_fault || dst_fault;
    end

    // state transitions: accept (IDLE->RESP), retire (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign req_ready = (state_q == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_addr     <= '0;
            rsp_be       <= '0;
            rsp_we       <= 1'b0;
            rsp_wdata    <= '0;
            rsp_rd32     <= 1'b0;
            rsp_new_sp   <= '0;
            rsp_fault    <= 1'b0;
            rsp_dst_addr <= '0;
            rsp_dst_we   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_addr     <= acc_off;
                rsp_be       <= any_fault ? 4'b0000 : lanes;
                rsp_we       <= !req_pop && !any_fault;
                rsp_wdata    <= req_pop ? '0 : {{(SP_W-SEL_W){1'b0}}, req_sel};
                rsp_rd32     <= req_pop && wide;
                rsp_new_sp   <= any_fault ? req_sp : next_sp;
                rsp_fault    <= any_fault;
                rsp_dst_addr <= (req_pop && req_pop_to_mem) ? (dst_base + req_dst_off) : '0;
                rsp_dst_we   <= req_pop && req_pop_to_mem && !any_fault;
            end
        end
    end

    // R12
    rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R12
    rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R7
    fault_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_we && !rsp_dst_we && rsp_be == 4'b0000
                                      && rsp_new_sp == $past(req_sp)));
    // R3
    push_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_we) |-> (rsp_wdata[SP_W-1:SEL_W] == '0));
    // R2
    narrow_two_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && !$past(req_mode_wide)) |-> (rsp_be == 4'b0011 && !rsp_rd32));
    // R8
    seg16_upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_ss32)) |-> (rsp_new_sp[SP_W-1:WRAP_W] == $past(req_sp[SP_W-1:WRAP_W])));
endmodule

// File: tb/tb_ssel_unit.sv
`timescale 1ns/1ps
module tb_ssel_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_pop = 1'b0, req_pop_to_mem = 1'b0;
    logic        req_opsz32 = 1'b0, req_ss32 = 1'b0, req_mode_wide = 1'b0;
    logic [31:0] req_sp = '0, req_limit = '0, req_dst_off = '0;
    logic [15:0] req_sel = '0;
    logic        req_ready, rsp_valid, rsp_we, rsp_rd32, rsp_fault, rsp_dst_we;
    logic [31:0] rsp_addr, rsp_wdata, rsp_new_sp, rsp_dst_addr;
    logic [3:0]  rsp_be;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    ssel_unit dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pop(req_pop), .req_pop_to_mem(req_pop_to_mem), .req_opsz32(req_opsz32),
        .req_ss32(req_ss32), .req_mode_wide(req_mode_wide), .req_sp(req_sp),
        .req_limit(req_limit), .req_sel(req_sel), .req_dst_off(req_dst_off),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_be(rsp_be), .rsp_we(rsp_we),
        .rsp_wdata(rsp_wdata), .rsp_rd32(rsp_rd32), .rsp_new_sp(rsp_new_sp),
        .rsp_fault(rsp_fault), .rsp_dst_addr(rsp_dst_addr), .rsp_dst_we(rsp_dst_we)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge; return at the falling edge where rsp_valid is up
    task automatic issue(input logic pop, input logic ptm, input logic o32, input logic s32,
                         input logic wide, input logic [31:0] sp, input logic [31:0] lim,
                         input logic [15:0] sel, input logic [31:0] off);
        req_pop = pop; req_pop_to_mem = ptm; req_opsz32 = o32; req_ss32 = s32;
        req_mode_wide = wide; req_sp = sp; req_limit = lim; req_sel = sel; req_dst_off = off;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_req();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R12 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R12 reset req_ready", {31'b0, req_ready}, 32'd1);
    endtask

    task automatic t_push_narrow();
        issue(0, 0, 0, 1, 0, 32'h1000, 32'hFFFFF, 16'hABCD, 0);
        chk("R12 rsp_valid", {31'b0, rsp_valid}, 1);
        chk("R12 busy", {31'b0, req_ready}, 0);
        chk("R1 new_sp 16", rsp_new_sp, 32'h0FFE);
        chk("R1 addr 16", rsp_addr, 32'h0FFE);
        chk("R2 be 16", {28'b0, rsp_be}, 4'b0011);
        chk("R2 wdata", rsp_wdata, 32'h0000ABCD);
        chk("R2 we", {31'b0, rsp_we}, 1);
        finish_req();
        chk("R12 one cycle", {31'b0, rsp_valid}, 0);
        chk("R12 ready again", {31'b0, req_ready}, 1);
        issue(0, 0, 1, 1, 0, 32'h1000, 32'hFFFFF, 16'h1234, 0);
        chk("R1 new_sp 32", rsp_new_sp, 32'h0FFC);
        chk("R2 be 32 narrow", {28'b0, rsp_be}, 4'b0011);
        finish_req();
    endtask

    task automatic t_push_wide();
        issue(0, 0, 1, 1, 1, 32'h1000, 32'hFFFFF, 16'h5A5A, 0);
        chk("R3 be", {28'b0, rsp_be}, 4'b1111);
        chk("R3 wdata", rsp_wdata, 32'h00005A5A);
        chk("R3 new_sp", rsp_new_sp, 32'h0FFC);
        finish_req();
        issue(0, 0, 0, 1, 1, 32'h1000, 32'hFFFFF, 16'h5A5A, 0);
        chk("R3 be 16", {28'b0, rsp_be}, 4'b0011);
        finish_req();
    endtask

    task automatic t_pop_modes();
        issue(1, 0, 1, 1, 0, 32'h2000, 32'hFFFFF, 0, 0);
        chk("R4 addr", rsp_addr, 32'h2000);
        chk("R4 new_sp", rsp_new_sp, 32'h2004);
        chk("R4 be", {28'b0, rsp_be}, 4'b0011);
        chk("R4 rd32", {31'b0, rsp_rd32}, 0);
        chk("R4 we", {31'b0, rsp_we}, 0);
        finish_req();
        issue(1, 0, 1, 1, 1, 32'h2000, 32'hFFFFF, 0, 0);
        chk("R5 rd32", {31'b0, rsp_rd32}, 1);
        chk("R5 be", {28'b0, rsp_be}, 4'b1111);
        chk("R5 new_sp", rsp_new_sp, 32'h2004);
        finish_req();
        issue(1, 0, 0, 1, 1, 32'h2000, 32'hFFFFF, 0, 0);
        chk("R5 new_sp 16", rsp_new_sp, 32'h2002);
        chk("R5 rd32 16", {31'b0, rsp_rd32}, 0);
        finish_req();
    endtask

    task automatic t_limit();
        issue(1, 0, 1, 1, 1, 32'h2000, 32'h2002, 0, 0);
        chk("R6 wide fault", {31'b0, rsp_fault}, 1);
        chk("R7 sp held", rsp_new_sp, 32'h2000);
        chk("R7 be off", {28'b0, rsp_be}, 0);
        finish_req();
        issue(1, 0, 1, 1, 1, 32'h2000, 32'h2003, 0, 0);
        chk("R6 wide edge ok", {31'b0, rsp_fault}, 0);
        finish_req();
        issue(1, 0, 1, 1, 0, 32'h2000, 32'h2001, 0, 0);
        chk("R6 narrow no fault", {31'b0, rsp_fault}, 0);
        chk("R6 narrow sp", rsp_new_sp, 32'h2004);
        finish_req();
        issue(1, 0, 1, 1, 0, 32'h2000, 32'h2000, 0, 0);
        chk("R6 narrow fault", {31'b0, rsp_fault}, 1);
        finish_req();
        issue(0, 0, 1, 1, 1, 32'h1000, 32'h0FFD, 16'h7777, 0);
        chk("R7 push fault", {31'b0, rsp_fault}, 1);
        chk("R7 no write", {31'b0, rsp_we}, 0);
        chk("R7 push sp held", rsp_new_sp, 32'h1000);
        finish_req();
    endtask

    task automatic t_seg16();
        issue(1, 0, 1, 0, 0, 32'hABCD_FFFC, 32'hFFFF, 0, 0);
        chk("R8 addr", rsp_addr, 32'h0000_FFFC);
        chk("R8 wrap 32", rsp_new_sp, 32'hABCD_0000);
        finish_req();
        issue(1, 0, 0, 0, 1, 32'hABCD_FFFE, 32'hFFFF, 0, 0);
        chk("R8 wrap 16", rsp_new_sp, 32'hABCD_0000);
        finish_req();
        issue(0, 0, 0, 0, 0, 32'h0001_0000, 32'hFFFF, 16'h1111, 0);
        chk("R8 push wrap sp", rsp_new_sp, 32'h0001_FFFE);
        chk("R8 push wrap addr", rsp_addr, 32'h0000_FFFE);
        finish_req();
        issue(1, 0, 1, 1, 0, 32'h0000_FFFC, 32'h1FFFF, 0, 0);
        chk("R9 no wrap", rsp_new_sp, 32'h0001_0000);
        finish_req();
    endtask

    task automatic t_pop_to_mem();
        issue(1, 1, 1, 0, 0, 32'h0000_FFFC, 32'hFFFF, 0, 32'h20);
        chk("R10 dst", rsp_dst_addr, 32'h20);
        chk("R10 dst_we", {31'b0, rsp_dst_we}, 1);
        chk("R10 sp", rsp_new_sp, 32'h0);
        finish_req();
        issue(1, 1, 0, 0, 0, 32'h0000_1000, 32'hFFFF, 0, 32'h8);
        chk("R10 dst plain", rsp_dst_addr, 32'h100A);
        finish_req();
        issue(1, 1, 1, 0, 1, 32'h0000_FFFC, 32'hFFFF, 0, 32'h20);
        chk("R11 fault", {31'b0, rsp_fault}, 1);
        chk("R11 no dst write", {31'b0, rsp_dst_we}, 0);
        chk("R11 sp held", rsp_new_sp, 32'h0000_FFFC);
        finish_req();
        issue(1, 1, 1, 0, 1, 32'h0000_FFFC, 32'h1FFFF, 0, 32'h20);
        chk("R11 dst high", rsp_dst_addr, 32'h0001_0020);
        chk("R11 dst_we", {31'b0, rsp_dst_we}, 1);
        chk("R11 no fault", {31'b0, rsp_fault}, 0);
        finish_req();
    endtask

    initial begin
        #50000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_push_narrow();
        t_push_wide();
        t_pop_modes();
        t_limit();
        t_seg16();
        t_pop_to_mem();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule